// File: doc/BRIEF.md
# Quad Lookup-Table Logic Analyzer Trigger

This block decides when a 16-channel logic analyzer capture should be marked as triggered. The sixteen input channels are split into four groups of four, called quads. Each quad owns a 16-entry truth table. The table is addressed by the quad's current 4-bit value, and its output says whether that quad matches. The level condition is met when all four quads match. A rising-edge mask and a falling-edge mask add per-channel transition conditions between the previous valid sample and the current one.

Software loads the tables and masks through a small write-only register port. A table can be written directly. It can also be built by a helper from a value/mask pair. The helper optionally stores the table reflected (entry j taken from entry 15-j), which matches the complement of the requested pattern. Once armed, the unit counts valid samples. On the first sample that satisfies every enabled condition, it emits a single-cycle pulse and latches the index of that sample. It then stays quiet until it is armed again.

Top module: `quad_lut_trigger`

## Requirements
- R1: After reset every table entry is 1 (don't care), both edge masks are zero, the unit is disarmed, `trig_pulse` is 0 and `trig_index` is 0.
- R2: Quad q is formed from channels 4q (index bit 0) to 4q+3 (index bit 3). A write to address q (0..3) loads `cfg_wdata` into that quad's table. The level condition is the AND, over all quads, of table bit [quad value].
- R3: A write to address 6 stores a helper value. A write to address 7 rebuilds all four tables from that value and the written mask. In quad q, entry j is cleared when some channel k of the quad has its mask bit set and a value bit that differs from bit k of j. All other entries are set, so a mask of zero gives all-ones tables.
- R4: When `cfg_neg` is high during the write to address 7, each rebuilt table is stored reflected: entry j takes the built entry 15-j.
- R5: Address 4 holds the rising mask. Each channel set in it must be 0 in the previous valid sample and 1 in the current one.
- R6: Address 5 holds the falling mask. Each channel set in it must be 1 in the previous valid sample and 0 in the current one.
- R7: When either edge mask is non-zero, the first valid sample after arming can never fire.
- R8: A hit raises `trig_pulse` for exactly one cycle, on the cycle after the hitting sample. `trig_index` then shows the 0-based count of valid samples since arming, and holds that value until the next hit.
- R9: After a hit the unit is disarmed. Samples do not fire again until `arm` is pulsed.
- R10: A cycle with `smp_valid` low neither evaluates, counts, nor updates the previous-sample register.
- R11: Pulsing `arm` while already armed restarts the sample index at 0 and the first-sample rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration address |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_neg | input | 1 | Store helper-built tables reflected |
| arm | input | 1 | Arm and restart the trigger |
| smp_valid | input | 1 | Sample qualifier |
| smp_data | input | 16 | Channel sample |
| trig_pulse | output | 1 | One-cycle trigger pulse |
| trig_index | output | 16 | Sample index of the last trigger |

## Verification
Directly written tables are tried with patterns that put the required nibble in the wrong quad and then in the right one, which separates correct channel grouping from swapped quads. Helper-built tables are tried with wide and single-channel masks, with samples that differ only in a masked bit or only in unmasked bits. The reflected build is tried with the pattern and with its complement. The edge tests present steady, rising and falling sequences, a candidate edge on the first sample after arming, and an invalid cycle holding a changed value, so that a previous-sample register loading at the wrong time would show up as a wrong pulse or a wrong index.

// File: rtl/qlt_pkg.sv
package qlt_pkg;

    localparam int QUAD_W = 4;
    localparam int LUT_W  = 1 << QUAD_W;

    typedef logic [LUT_W-1:0] lut_t;

    // Truth table for one quad from a masked value compare
    function automatic lut_t build_lut(input logic [QUAD_W-1:0] val,
                                       input logic [QUAD_W-1:0] msk);
        lut_t t;
        logic [QUAD_W-1:0] jv;
        t = '1;
        for (int j = 0; j < LUT_W; j++) begin
            jv = QUAD_W'(j);
            for (int k = 0; k < QUAD_W; k++) begin
                if (msk[k] && (val[k] != jv[k])) begin
                    t[j] = 1'b0;
                end
            end
        end
        return t;
    endfunction

    // Reflected table: every index complemented
    function automatic lut_t mirror_lut(input lut_t t);
        lut_t r;
        for (int j = 0; j < LUT_W; j++) begin
            r[j] = t[LUT_W-1-j];
        end
        return r;
    endfunction

endpackage

// File: rtl/qlt_cfg.sv
module qlt_cfg
    import qlt_pkg::*;
#(
    parameter  int NUM_QUADS = 4,
    parameter  int ADDR_W    = 3,
    localparam int CH        = NUM_QUADS * QUAD_W
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                cfg_we,
    input  logic [ADDR_W-1:0]                   cfg_addr,
    input  logic [CH-1:0]                       cfg_wdata,
    input  logic                                cfg_neg,
    output logic [NUM_QUADS-1:0][LUT_W-1:0]     lut_o,
    output logic [CH-1:0]                       rise_o,
    output logic [CH-1:0]                       fall_o
);

    localparam logic [ADDR_W-1:0] A_RISE  = ADDR_W'(NUM_QUADS);
    localparam logic [ADDR_W-1:0] A_FALL  = ADDR_W'(NUM_QUADS + 1);
    localparam logic [ADDR_W-1:0] A_HVAL  = ADDR_W'(NUM_QUADS + 2);
    localparam logic [ADDR_W-1:0] A_APPLY = ADDR_W'(NUM_QUADS + 3);

    typedef struct packed {
        logic [NUM_QUADS-1:0][LUT_W-1:0] lut;
        logic [CH-1:0]                   rise;
        logic [CH-1:0]                   fall;
        logic [CH-1:0]                   hval;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    lut_t built;

    always_comb begin
        cfg_d = cfg_q;
        built = '1;
        if (cfg_we) begin
            for (int q = 0; q < NUM_QUADS; q++) begin
                if (cfg_addr == ADDR_W'(q)) begin
                    cfg_d.lut[q] = LUT_W'(cfg_wdata);
                end
            end
            if (cfg_addr == A_RISE) cfg_d.rise = cfg_wdata;
            if (cfg_addr == A_FALL) cfg_d.fall = cfg_wdata;
            if (cfg_addr == A_HVAL) cfg_d.hval = cfg_wdata;
            if (cfg_addr == A_APPLY) begin
                for (int q = 0; q < NUM_QUADS; q++) begin
                    built = build_lut(cfg_q.hval[q*QUAD_W +: QUAD_W],
                                      cfg_wdata[q*QUAD_W +: QUAD_W]);
                    cfg_d.lut[q] = cfg_neg ? mirror_lut(built) : built;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.lut  <= '1;
            cfg_q.rise <= '0;
            cfg_q.fall <= '0;
            cfg_q.hval <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign lut_o  = cfg_q.lut;
    assign rise_o = cfg_q.rise;
    assign fall_o = cfg_q.fall;

    // R3: a zero mask leaves every table fully don't-care
    p_zero_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == A_APPLY && cfg_wdata == '0) |=> (lut_o == '1));

    // R2: direct write to quad 0 lands in quad 0's table
    p_direct_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == '0) |=> (lut_o[0] == LUT_W'($past(cfg_wdata))));

endmodule

// File: rtl/qlt_match.sv
module qlt_match
    import qlt_pkg::*;
#(
    parameter  int NUM_QUADS = 4,
    localparam int CH        = NUM_QUADS * QUAD_W
) (
    input  logic [NUM_QUADS-1:0][LUT_W-1:0] lut_i,
    input  logic [CH-1:0]                   rise_i,
    input  logic [CH-1:0]                   fall_i,
    input  logic [CH-1:0]                   cur_i,
    input  logic [CH-1:0]                   prev_i,
    input  logic                            first_i,
    output logic                            edge_en_o,
    output logic                            hit_o
);

    logic [NUM_QUADS-1:0] quad_hit;
    logic                 level_ok;
    logic                 rise_ok;
    logic                 fall_ok;

    for (genvar q = 0; q < NUM_QUADS; q++) begin : g_quad
        assign quad_hit[q] = lut_i[q][cur_i[q*QUAD_W +: QUAD_W]];
    end

    assign level_ok  = &quad_hit;
    assign rise_ok   = ((~prev_i & cur_i & rise_i) == rise_i);
    assign fall_ok   = ((prev_i & ~cur_i & fall_i) == fall_i);
    assign edge_en_o = |(rise_i | fall_i);
    assign hit_o     = level_ok && (!edge_en_o || (rise_ok && fall_ok && !first_i));

endmodule

// File: rtl/quad_lut_trigger.sv
module quad_lut_trigger
    import qlt_pkg::*;
#(
    parameter  int NUM_QUADS = 4,
    parameter  int IDX_W     = 16,
    localparam int CH        = NUM_QUADS * QUAD_W,
    localparam int ADDR_W    = $clog2(NUM_QUADS + 4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CH-1:0]     cfg_wdata,
    input  logic              cfg_neg,
    input  logic              arm,
    input  logic              smp_valid,
    input  logic [CH-1:0]     smp_data,
    output logic              trig_pulse,
    output logic [IDX_W-1:0]  trig_index
);

    typedef struct packed {
        logic             armed;
        logic             first;
        logic [CH-1:0]    prev;
        logic [IDX_W-1:0] cnt;
        logic             pulse;
        logic [IDX_W-1:0] idx;
    } st_t;

    st_t st_d, st_q;

    logic [NUM_QUADS-1:0][LUT_W-1:0] lut;
    logic [CH-1:0]                   rise_m;
    logic [CH-1:0]                   fall_m;
    logic                            edge_en;
    logic                            hit;

    qlt_cfg #(.NUM_QUADS(NUM_QUADS), .ADDR_W(ADDR_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_neg   (cfg_neg),
        .lut_o     (lut),
        .rise_o    (rise_m),
        .fall_o    (fall_m)
    );

    qlt_match #(.NUM_QUADS(NUM_QUADS)) u_match (
        .lut_i     (lut),
        .rise_i    (rise_m),
        .fall_i    (fall_m),
        .cur_i     (smp_data),
        .prev_i    (st_q.prev),
        .first_i   (st_q.first),
        .edge_en_o (edge_en),
        .hit_o     (hit)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (smp_valid) begin
            st_d.prev = smp_data;
        end
        if (arm) begin
            st_d.armed = 1'b1;
            st_d.first = 1'b1;
            st_d.cnt   = '0;
        end else if (st_q.armed && smp_valid) begin
            st_d.cnt   = st_q.cnt + 1'b1;
            st_d.first = 1'b0;
            if (hit) begin
                st_d.pulse = 1'b1;
                st_d.idx   = st_q.cnt;
                st_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign trig_pulse = st_q.pulse;
    assign trig_index = st_q.idx;

    // R8: pulse never lasts two cycles
    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |=> !trig_pulse);

    // R8: index only moves together with a pulse
    p_index_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_pulse |-> $stable(trig_index));

    // R9: a pulse leaves the unit disarmed
    p_disarm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> !st_q.armed);

    // R9: a pulse needs an armed unit that saw a valid sample
    p_from_armed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> $past(st_q.armed && smp_valid && !arm));

    // R7: first sample after arming cannot fire with edges enabled
    p_first_no_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && st_q.first && smp_valid && !arm && edge_en) |=> !trig_pulse);

    // R10: idle cycles keep the previous sample and fire nothing
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> ($stable(st_q.prev) && !trig_pulse));

endmodule

// File: tb/quad_lut_trigger_tb.sv
module quad_lut_trigger_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        cfg_neg = 1'b0;
    logic        arm = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic        trig_pulse;
    logic [15:0] trig_index;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    quad_lut_trigger u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_neg    (cfg_neg),
        .arm        (arm),
        .smp_valid  (smp_valid),
        .smp_data   (smp_data),
        .trig_pulse (trig_pulse),
        .trig_index (trig_index)
    );

    task automatic expect_trig(input bit exp, input int idx, input string tag);
        checks++;
        if (trig_pulse !== exp || (exp && trig_index !== 16'(idx))) begin
            fails++;
            $display("FAIL %s: pulse=%0b index=%0d expected pulse=%0b index=%0d",
                     tag, trig_pulse, trig_index, exp, idx);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d, input bit neg);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_neg = neg;
        @(negedge clk);
        cfg_we = 1'b0; cfg_neg = 1'b0;
    endtask

    task automatic do_arm();
        @(negedge clk);
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
    endtask

    // Drive one valid sample; the pulse is visible when this returns
    task automatic send(input logic [15:0] d);
        @(negedge clk);
        smp_valid = 1'b1; smp_data = d;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic t_reset();
        expect_trig(1'b0, 0, "R1 reset pulse");
        checks++;
        if (trig_index !== 16'd0) begin
            fails++;
            $display("FAIL R1 reset index: got %0d expected 0", trig_index);
        end
        do_arm();
        send(16'h1234);
        expect_trig(1'b1, 0, "R1 all-ones tables fire");
        @(negedge clk);
        expect_trig(1'b0, 0, "R8 pulse lasts one cycle");
    endtask

    task automatic t_direct();
        wr(3'd1, 16'h0020, 1'b0);
        do_arm();
        send(16'h0030);
        expect_trig(1'b0, 0, "R2 quad1 wrong value");
        send(16'h0050);
        expect_trig(1'b1, 1, "R2 quad1 value 5");
        send(16'h0050);
        expect_trig(1'b0, 0, "R9 disarmed after hit");
        wr(3'd1, 16'hFFFF, 1'b0);
        wr(3'd3, 16'h0400, 1'b0);
        do_arm();
        send(16'h0A00);
        expect_trig(1'b0, 0, "R2 nibble in quad2 not quad3");
        send(16'hA000);
        expect_trig(1'b1, 1, "R2 quad3 value A");
        wr(3'd3, 16'hFFFF, 1'b0);
    endtask

    task automatic t_helper();
        wr(3'd6, 16'h0050, 1'b0);
        wr(3'd7, 16'h00F0, 1'b0);
        do_arm();
        send(16'h0040);
        expect_trig(1'b0, 0, "R3 masked quad mismatch");
        send(16'hFF5F);
        expect_trig(1'b1, 1, "R3 unmasked bits ignored");
        wr(3'd6, 16'h0002, 1'b0);
        wr(3'd7, 16'h0003, 1'b0);
        do_arm();
        send(16'h0001);
        expect_trig(1'b0, 0, "R3 ch0 high, ch1 low");
        send(16'h0003);
        expect_trig(1'b0, 0, "R3 ch0 must be low");
        send(16'hFFFE);
        expect_trig(1'b1, 2, "R3 single-channel match");
    endtask

    task automatic t_neg();
        wr(3'd6, 16'h0050, 1'b0);
        wr(3'd7, 16'h00F0, 1'b1);
        do_arm();
        send(16'h0050);
        expect_trig(1'b0, 0, "R4 reflected rejects pattern");
        send(16'h00A0);
        expect_trig(1'b1, 1, "R4 reflected accepts complement");
        wr(3'd7, 16'h0000, 1'b0);
    endtask

    task automatic t_rise();
        wr(3'd4, 16'h0008, 1'b0);
        do_arm();
        send(16'h0000);
        expect_trig(1'b0, 0, "R5 first sample");
        send(16'h0000);
        expect_trig(1'b0, 0, "R5 steady low");
        send(16'h0008);
        expect_trig(1'b1, 2, "R5 rising ch3");
        wr(3'd4, 16'h0000, 1'b0);
    endtask

    task automatic t_fall();
        wr(3'd5, 16'h0100, 1'b0);
        do_arm();
        send(16'h0100);
        expect_trig(1'b0, 0, "R6 first sample");
        send(16'h0100);
        expect_trig(1'b0, 0, "R6 steady high");
        send(16'h0000);
        expect_trig(1'b1, 2, "R6 falling ch8");
        wr(3'd5, 16'h0000, 1'b0);
    endtask

    task automatic t_first();
        wr(3'd4, 16'h0001, 1'b0);
        send(16'h0000);
        expect_trig(1'b0, 0, "R9 disarmed sample");
        do_arm();
        send(16'h0001);
        expect_trig(1'b0, 0, "R7 edge on first sample");
        send(16'h0000);
        expect_trig(1'b0, 0, "R7 falling back");
        send(16'h0001);
        expect_trig(1'b1, 2, "R7 later edge fires");
    endtask

    task automatic t_valid();
        do_arm();
        send(16'h0000);
        expect_trig(1'b0, 0, "R10 first low sample");
        @(negedge clk);
        smp_data = 16'h0001;
        @(negedge clk);
        expect_trig(1'b0, 0, "R10 invalid high not evaluated");
        send(16'h0001);
        expect_trig(1'b1, 1, "R10 edge against held prev and count");
        wr(3'd4, 16'h0000, 1'b0);
    endtask

    task automatic t_rearm();
        wr(3'd0, 16'h8000, 1'b0);
        do_arm();
        send(16'h0000);
        send(16'h0000);
        expect_trig(1'b0, 0, "R11 no match before re-arm");
        do_arm();
        send(16'h000F);
        expect_trig(1'b1, 0, "R11 index restarts at 0");
        wr(3'd0, 16'hFFFF, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direct();
        t_helper();
        t_neg();
        t_rise();
        t_fall();
        t_first();
        t_valid();
        t_rearm();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule